// File: doc/BRIEF.md
# Chip-Enable Gate With Write Completion

This block sits between a processor's address decoder and a memory. It forwards an active-low chip-enable to the memory while the system is out of reset. While the system is in reset it holds the memory enable inactive (high). The memory is then shielded from spurious accesses while the supply is ramping up or collapsing.

When reset arrives in the middle of an access, the enable is not cut at once. The access already in progress is allowed to finish. The output stays low until the processor releases the enable or a bounded grace window runs out, whichever comes first. After that the gate refuses any new access until reset is released.

The block is a three-state machine:
- `ST_PASS` (encoding 1): the input is forwarded combinationally.
- `ST_GRACE` (encoding 2): a write that was open when reset arrived is allowed to complete.
- `ST_BLOCKED` (encoding 0): the output is held high.

Its transitions are:
- Power-on initialisation → BLOCKED.
- BLOCKED → PASS when reset is sampled low.
- PASS → BLOCKED when reset is sampled high with the input high.
- PASS → GRACE when reset is sampled high with the input low.
- GRACE → PASS when reset is sampled low.
- GRACE → BLOCKED when the input rises or the window expires.

Top module: `ce_write_guard`

## Requirements
- R1: In PASS the output equals the input combinationally, within the same cycle, with no clock latency.
- R2: While `rst_n` is low the machine is in BLOCKED and `ce_out_n` is 1, whatever `ce_in_n` does.
- R3: In BLOCKED with `sys_reset` high, `ce_out_n` stays 1 and any activity on `ce_in_n` has no effect on it.
- R4: BLOCKED moves to PASS at the first clock edge that samples `sys_reset` low. The output follows the input from the following cycle, and is still 1 in the cycle in which `sys_reset` first falls.
- R5: If `sys_reset` is seen while in PASS with `ce_in_n` high, `ce_out_n` is 1 in that same cycle and the machine enters BLOCKED.
- R6: If `sys_reset` is seen while in PASS with `ce_in_n` low, the machine enters GRACE. The output can stay low for at most `GRACE_CYCLES` cycles, counted from and including the cycle in which reset is first seen. In cycle `GRACE_CYCLES` the output is 1.
- R7: In GRACE a rising input drives `ce_out_n` high in the same cycle and ends the window. A later low input is ignored until reset is released.
- R8: If `sys_reset` is sampled low during GRACE, the machine returns to PASS and the output does not rise. This holds even when release falls on the last cycle of the window; release takes precedence over expiry.
- R9: `ce_out_n` is low only when `ce_in_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on initialisation, active low, forces BLOCKED |
| sys_reset | input | 1 | System reset state from the supervisor, active high |
| ce_in_n | input | 1 | Chip-enable from the decoder, active low |
| ce_out_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
Two events can land in one cycle: release of reset and the final cycle of the grace window. The bench asserts reset over an open access and then releases it after every possible number of window cycles, from 1 to `GRACE_CYCLES`. The output must stay low throughout whenever release arrives on or before the last window cycle. It must show exactly one high cycle when release comes one cycle later. A second sweep moves the input's rise across the window and past it. The expected output in each cycle is computed as the minimum of the rise point and the window length.

// File: rtl/ce_gate_pkg.sv
package ce_gate_pkg;

    typedef enum logic [1:0] {
        ST_BLOCKED = 2'd0,
        ST_PASS    = 2'd1,
        ST_GRACE   = 2'd2
    } gate_state_e;

endpackage

// File: rtl/ce_grace_timer.sv
module ce_grace_timer #(
    parameter int GRACE_CYCLES = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(GRACE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(GRACE_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Window cycle 0 is the PASS cycle in which reset was first seen; GRACE starts at 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(1);
        end else if (run && !expired) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = (cnt == LAST);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_start_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == CW'(1)));

endmodule

// File: rtl/ce_gate_fsm.sv
module ce_gate_fsm
    import ce_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_reset,
    input  logic        ce_in_n,
    input  logic        grace_done,
    output gate_state_e state,
    output logic        start_grace,
    output logic        run_grace
);
    gate_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BLOCKED: if (!sys_reset) state_nx = ST_PASS;
            ST_PASS: begin
                if (sys_reset) state_nx = ce_in_n ? ST_BLOCKED : ST_GRACE;
            end
            ST_GRACE: begin
                if (!sys_reset)                 state_nx = ST_PASS;
                else if (ce_in_n || grace_done) state_nx = ST_BLOCKED;
            end
            default: state_nx = ST_BLOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BLOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        start_grace = (state == ST_PASS) && sys_reset && !ce_in_n;
        run_grace   = (state == ST_GRACE);
    end

    assert_enter_grace_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PASS) && sys_reset && !ce_in_n) |=> (state == ST_GRACE));

    assert_enter_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PASS) && sys_reset && ce_in_n) |=> (state == ST_BLOCKED));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_GRACE) && !sys_reset) |=> (state == ST_PASS));

    assert_unblock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BLOCKED) && !sys_reset) |=> (state == ST_PASS));

endmodule

// File: rtl/ce_out_stage.sv
module ce_out_stage
    import ce_gate_pkg::*;
(
    input  gate_state_e state,
    input  logic        ce_in_n,
    output logic        ce_out_n
);
    always_comb begin
        unique case (state)
            ST_PASS:    ce_out_n = ce_in_n;
            ST_GRACE:   ce_out_n = ce_in_n;
            ST_BLOCKED: ce_out_n = 1'b1;
            default:    ce_out_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/ce_write_guard.sv
module ce_write_guard
    import ce_gate_pkg::*;
#(
    parameter int GRACE_CYCLES = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_reset,
    input  logic ce_in_n,
    output logic ce_out_n
);
    localparam int LW = $clog2(GRACE_CYCLES + 2);

    gate_state_e state;
    logic        start_grace;
    logic        run_grace;
    logic        grace_done;

    ce_gate_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_reset  (sys_reset),
        .ce_in_n    (ce_in_n),
        .grace_done (grace_done),
        .state      (state),
        .start_grace(start_grace),
        .run_grace  (run_grace)
    );

    ce_grace_timer #(.GRACE_CYCLES(GRACE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_grace),
        .run    (run_grace),
        .expired(grace_done)
    );

    ce_out_stage u_out (
        .state   (state),
        .ce_in_n (ce_in_n),
        .ce_out_n(ce_out_n)
    );

    // Checker: length of the current run of low output cycles under reset.
    logic [LW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        low_run <= '0;
        else if (sys_reset && !ce_out_n)   low_run <= low_run + LW'(1);
        else                               low_run <= '0;
    end

    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset && !ce_out_n) |-> (low_run < LW'(GRACE_CYCLES)));

    assert_low_needs_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_out_n |-> !ce_in_n);

    assert_no_relow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset && $past(sys_reset) && $past(ce_out_n)) |-> ce_out_n);

    always_comb begin
        if (!rst_n) assert_init_high_R2: assert (ce_out_n);
    end

endmodule

// File: tb/ce_write_guard_bench.sv
module ce_write_guard_bench;
    localparam int N = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_reset = 1'b1;
    logic ce_in_n = 1'b0;
    logic ce_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ce_write_guard #(.GRACE_CYCLES(N)) u_ce_write_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_reset(sys_reset),
        .ce_in_n  (ce_in_n),
        .ce_out_n (ce_out_n)
    );

    task automatic check(input string req, input logic expv);
        checks++;
        if (ce_out_n !== expv) begin
            fails++;
            $display("FAIL %s: ce_out_n=%b expected=%b at %0t", req, ce_out_n, expv, $time);
        end
    endtask

    task automatic cyc(input logic rs, input logic ce);
        @(negedge clk);
        sys_reset = rs;
        ce_in_n   = ce;
        #2;
    endtask

    initial begin
        // R2: initialisation forces high
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, i[0]);
            check("R2", 1'b1);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R3: blocked during power-up, input ignored
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, i[0]);
            check("R3", 1'b1);
        end
        // R4: release, still high this cycle, follows next cycle
        cyc(1'b0, 1'b0);
        check("R4", 1'b1);
        cyc(1'b0, 1'b0);
        check("R4", 1'b0);
        // R1: combinational pass-through, every 4-bit pattern
        for (int v = 0; v < 16; v++) begin
            for (int b = 0; b < 4; b++) begin
                cyc(1'b0, v[b]);
                check("R1", v[b]);
                ce_in_n = ~v[b];
                #2;
                check("R1", ~v[b]);
            end
        end
        // R5: reset seen with input high
        cyc(1'b1, 1'b1);
        check("R5", 1'b1);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, 1'b0);
            check("R3", 1'b1);
        end
        cyc(1'b0, 1'b0);
        check("R4", 1'b1);
        cyc(1'b0, 1'b0);
        check("R4", 1'b0);
        // R6/R7: input rise swept across and beyond the window
        for (int r = 1; r <= N + 1; r++) begin
            for (int j = 0; j <= N + 3; j++) begin
                cyc(1'b1, (j == r) ? 1'b1 : 1'b0);
                if (j < r && j < N) check("R6", 1'b0);
                else if (j >= N)    check("R6", 1'b1);
                else                check("R7", 1'b1);
            end
            cyc(1'b0, 1'b0);
            check("R4", 1'b1);
            cyc(1'b0, 1'b0);
            check("R4", 1'b0);
        end
        // R8: release swept across the window, including its last cycle
        for (int m = 1; m <= N; m++) begin
            for (int j = 0; j < m; j++) begin
                cyc(1'b1, 1'b0);
                check("R6", 1'b0);
            end
            cyc(1'b0, 1'b0);
            check("R8", (m < N) ? 1'b0 : 1'b1);
            cyc(1'b0, 1'b0);
            check("R8", 1'b0);
            cyc(1'b0, 1'b1);
            check("R9", 1'b1);
            cyc(1'b0, 1'b0);
            check("R1", 1'b0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule